// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block holds a single time-of-day alarm setting and compares it with a running BCD clock that is supplied from outside. The setting has three targets: seconds, minutes, and hours in 12-hour BCD form with a separate afternoon flag. Each target has its own enable bit. A target whose enable is clear takes no part in matching. When the supplied time first agrees with every enabled target, the block emits a one-cycle event pulse and sets a sticky status flag. Software clears that flag by writing a one to it.

A small register port gives access to the setting and to the status flag. The port has an address, write data, a write strobe and combinational read data. A lock input blocks every write while it is high. A target can be changed safely in three steps: clear its enable, write the new value, then set the enable again. While the enable is clear, the half-updated field can never raise an alarm.

Top module: `rtc_time_alarm`

## Requirements
- R1: After reset the alarm word reads 0x00000000, the status flag reads 0 and `alarm_pulse` is low.
- R2: A write to address 0 loads bits 23:0 of the data into the alarm word. The fields are: seconds target bits 6:0, seconds enable bit 7, minutes target bits 14:8, minutes enable bit 15, hour target bits 21:16, afternoon bit 22, hour enable bit 23. Bits 31:24 always read as zero.
- R3: While `wr_lock` is high, writes to every address are ignored. The alarm word is unchanged and the status flag is not cleared. Reads still return the stored contents.
- R4: With the seconds enable set, the seconds target takes part in the match against `cur_sec`.
- R5: With the minutes enable set, the minutes target takes part in the match against `cur_min`.
- R6: With the hour enable set, both the hour digits and the afternoon bit must equal `cur_hour` and `cur_pm`.
- R7: A field whose enable is clear is ignored. With no enable set, no alarm is ever raised.
- R8: `alarm_pulse` goes high for exactly one cycle, one clock after the first cycle in which all enabled fields match. It does not fire again until the match has gone false and then true again.
- R9: The status flag reads in bit 0 of address 1. It is set together with `alarm_pulse` and stays set until a write to address 1 with data bit 0 high. If a new event arrives in the same cycle as the clear, the new event wins.
- R10: During the three-step update (clear the enable, write the new target, set the enable), no alarm is raised while the enable is clear, even when the new target equals the current time. Setting the enable then raises the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address (0 alarm word, 1 status) |
| reg_wdata | input | 32 | Write data |
| reg_wen | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| wr_lock | input | 1 | Write-protect lock; blocks all writes when high |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hour, BCD 01..12 |
| cur_pm | input | 1 | Current afternoon flag |
| alarm_pulse | output | 1 | One-cycle alarm event |
| alarm_flag | output | 1 | Sticky alarm status |

## Verification
Read data is combinational, so the bench checks a read in the same half-cycle in which it sets the address. A write takes effect at the next rising edge. The match uses the time inputs and the alarm word as they stand just before an edge, so `alarm_pulse` and the flag are due one rising edge after the stimulus. A new setting written at edge k therefore first shows in `alarm_pulse` after edge k+1. The bench drives all inputs just after a falling edge and samples every output at the following falling edge. It works out its expected pulse and flag from the values it has written and the time it has presented, keeping its own copy of the previous match.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

   localparam int unsigned FIELD_W = 7;
   localparam int unsigned N_FIELD = 3;

   // Field positions are fixed by the register layout.
   typedef struct packed {
      logic       hour_en;
      logic       pm;
      logic [5:0] hour;
      logic       min_en;
      logic [6:0] min;
      logic       sec_en;
      logic [6:0] sec;
   } alarm_cfg_t;

   localparam int unsigned CFG_W = $bits(alarm_cfg_t);

   typedef enum logic [0:0] {
      SEL_ALARM  = 1'b0,
      SEL_STATUS = 1'b1
   } reg_sel_e;

endpackage

// File: rtl/alm_regbank.sv
module alm_regbank
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_cfg,
   input  logic [DATA_W-1:0] wdata,
   output alarm_cfg_t        cfg
);

   if (DATA_W < CFG_W) begin : g_width_chk
      $error("alm_regbank: DATA_W too small for alarm word");
   end

   alarm_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_cfg) begin
         cfg_q <= alarm_cfg_t'(wdata[CFG_W-1:0]);
      end
   end

   assign cfg = cfg_q;

endmodule

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
   parameter int unsigned W = 7
) (
   input  logic         en,
   input  logic [W-1:0] target,
   input  logic [W-1:0] current,
   output logic         hit,
   output logic         used
);

   if (W < 1) begin : g_w_chk
      $error("alm_field_cmp: W must be positive");
   end

   // A disabled field always agrees, so it drops out of the AND.
   assign hit  = !en || (target == current);
   assign used = en;

endmodule

// File: rtl/alm_event.sv
module alm_event #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic match,
   input  logic clr,
   output logic pulse,
   output logic flag
);

   logic match_prev;
   logic rise;
   logic flag_q;

   assign rise = match && !match_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_prev <= 1'b0;
         flag_q     <= 1'b0;
      end else begin
         match_prev <= match;
         // A new event has priority over a clear in the same cycle.
         flag_q     <= rise || (flag_q && !clr);
      end
   end

   if (REG_OUT) begin : g_reg_out
      logic pulse_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= rise;
      end
      assign pulse = pulse_q;
   end else begin : g_comb_out
      assign pulse = rise;
   end

   assign flag = flag_q;

endmodule

// File: rtl/rtc_time_alarm.sv
module rtc_time_alarm
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned ALARM_ADDR  = 0,
   parameter int unsigned STATUS_ADDR = 1,
   parameter bit          REG_OUT     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_wen,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              wr_lock,
   input  logic [6:0]        cur_sec,
   input  logic [6:0]        cur_min,
   input  logic [5:0]        cur_hour,
   input  logic              cur_pm,
   output logic              alarm_pulse,
   output logic              alarm_flag
);

   localparam logic [ADDR_W-1:0] A_ALARM  = ADDR_W'(ALARM_ADDR);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_ADDR);

   if (ALARM_ADDR == STATUS_ADDR) begin : g_addr_chk
      $error("rtc_time_alarm: register addresses must differ");
   end
   if (ALARM_ADDR >= (1 << ADDR_W) || STATUS_ADDR >= (1 << ADDR_W)) begin : g_range_chk
      $error("rtc_time_alarm: address out of range");
   end

   logic       wr_ok;
   logic       wr_cfg;
   logic       clr_flag;
   alarm_cfg_t cfg_word;

   assign wr_ok    = reg_wen && !wr_lock;
   assign wr_cfg   = wr_ok && (reg_addr == A_ALARM);
   assign clr_flag = wr_ok && (reg_addr == A_STATUS) && reg_wdata[0];

   alm_regbank #(.DATA_W(DATA_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_cfg (wr_cfg),
      .wdata  (reg_wdata),
      .cfg    (cfg_word)
   );

   logic [N_FIELD-1:0][FIELD_W-1:0] tgt;
   logic [N_FIELD-1:0][FIELD_W-1:0] now;
   logic [N_FIELD-1:0]              ena;
   logic [N_FIELD-1:0]              hit;
   logic [N_FIELD-1:0]              used;

   assign tgt[0] = cfg_word.sec;
   assign tgt[1] = cfg_word.min;
   assign tgt[2] = {cfg_word.pm, cfg_word.hour};
   assign now[0] = cur_sec;
   assign now[1] = cur_min;
   assign now[2] = {cur_pm, cur_hour};
   assign ena    = {cfg_word.hour_en, cfg_word.min_en, cfg_word.sec_en};

   for (genvar i = 0; i < N_FIELD; i++) begin : g_field
      alm_field_cmp #(.W(FIELD_W)) u_cmp (
         .en      (ena[i]),
         .target  (tgt[i]),
         .current (now[i]),
         .hit     (hit[i]),
         .used    (used[i])
      );
   end

   logic match;
   assign match = (&hit) && (|used);

   alm_event #(.REG_OUT(REG_OUT)) u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .match (match),
      .clr   (clr_flag),
      .pulse (alarm_pulse),
      .flag  (alarm_flag)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_ALARM) begin
         reg_rdata[CFG_W-1:0] = cfg_word;
      end else if (reg_addr == A_STATUS) begin
         reg_rdata[0] = alarm_flag;
      end
   end

endmodule

// File: rtl/rtc_time_alarm_chk.sv
module rtc_time_alarm_chk
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned ALARM_ADDR = 0,
   parameter int unsigned STATUS_ADDR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              reg_wen,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              wr_lock,
   input logic              alarm_pulse,
   input logic              alarm_flag,
   input alarm_cfg_t        cfg_word
);

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_pulse |=> !alarm_pulse); // R8

   AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_pulse |-> alarm_flag); // R9

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag && !(reg_wen && !wr_lock && reg_addr == ADDR_W'(STATUS_ADDR) && reg_wdata[0]))
      |=> alarm_flag); // R9

   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lock |=> $stable(cfg_word)); // R3

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(ALARM_ADDR)) |-> (reg_rdata[DATA_W-1:CFG_W] == '0)); // R2

   AST_NO_EN_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_word.sec_en && !cfg_word.min_en && !cfg_word.hour_en) |=> !alarm_pulse); // R7

endmodule

bind rtc_time_alarm rtc_time_alarm_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ALARM_ADDR(ALARM_ADDR), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .reg_wen    (reg_wen),
   .reg_rdata  (reg_rdata),
   .wr_lock    (wr_lock),
   .alarm_pulse(alarm_pulse),
   .alarm_flag (alarm_flag),
   .cfg_word   (cfg_word)
);

// File: tb/rtc_time_alarm_bench.sv
`timescale 1ns/1ps
module rtc_time_alarm_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_wen = 1'b0;
   logic [31:0] reg_rdata;
   logic        wr_lock = 1'b0;
   logic [6:0]  cur_sec = '0;
   logic [6:0]  cur_min = '0;
   logic [5:0]  cur_hour = 6'h01;
   logic        cur_pm = 1'b0;
   logic        alarm_pulse;
   logic        alarm_flag;

   int checks = 0;
   int errors = 0;

   logic [23:0] m_word = '0;
   logic        m_prev = 1'b0;
   logic        m_flag = 1'b0;

   always #5 clk = ~clk;

   rtc_time_alarm u_rtc_time_alarm (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wen(reg_wen), .reg_rdata(reg_rdata), .wr_lock(wr_lock),
      .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_pm(cur_pm),
      .alarm_pulse(alarm_pulse), .alarm_flag(alarm_flag)
   );

   function automatic logic [6:0] bcd(input int v);
      return 7'(((v / 10) << 4) | (v % 10));
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Expected match from the documented field layout.
   function automatic logic model_match();
      logic ok;
      ok = m_word[7] || m_word[15] || m_word[23];
      if (m_word[7]  && m_word[6:0]   != cur_sec)           ok = 1'b0;
      if (m_word[15] && m_word[14:8]  != cur_min)           ok = 1'b0;
      if (m_word[23] && m_word[22:16] != {cur_pm, cur_hour}) ok = 1'b0;
      return ok;
   endfunction

   // One cycle: inputs already driven after a falling edge.
   task automatic step(input string req);
      logic em, ep, clr;
      em  = model_match();
      ep  = em && !m_prev;
      clr = reg_wen && !wr_lock && reg_addr == 4'd1 && reg_wdata[0];
      if (reg_wen && !wr_lock && reg_addr == 4'd0) m_word = reg_wdata[23:0];
      @(posedge clk);
      m_prev = em;
      m_flag = ep || (m_flag && !clr);
      @(negedge clk);
      reg_wen = 1'b0;
      check({req, " pulse"}, {31'b0, alarm_pulse}, {31'b0, ep});
      check({req, " flag"},  {31'b0, alarm_flag},  {31'b0, m_flag});
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d, input string req);
      reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
      step(req);
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   initial begin : watchdog
      #2000000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 pulse", {31'b0, alarm_pulse}, 32'h0);
      rd(4'd0, 32'h0, "R1 word");
      rd(4'd1, 32'h0, "R1 flag");
      rst_n = 1'b1;
      @(negedge clk);

      // R2: layout and upper bits read zero
      wr(4'd0, 32'hFF12_3456, "R2 write");
      rd(4'd0, 32'h0012_3456, "R2 readback");
      wr(4'd0, 32'h0, "R2 clear");
      rd(4'd0, 32'h0, "R2 zero");

      // R7: no enables, sweep seconds, no alarm
      for (int s = 0; s < 60; s++) begin
         cur_sec = bcd(s);
         step("R7 no enable");
      end

      // R4: seconds only, target 37, full sweep
      wr(4'd0, 32'h0000_00B7, "R4 set");
      for (int s = 0; s < 60; s++) begin
         cur_sec = bcd(s);
         step("R4 sec sweep");
      end
      wr(4'd1, 32'h1, "R9 clear");
      rd(4'd1, 32'h0, "R9 cleared");

      // R5: minutes 45 with seconds 00, sweep minutes
      cur_sec = 7'h00;
      wr(4'd0, 32'h0000_C580, "R5 set");
      for (int m = 0; m < 60; m++) begin
         cur_min = bcd(m);
         step("R5 min sweep");
      end

      // R6: hour 11 PM only, sweep 12h x AM/PM
      wr(4'd0, 32'h00D1_0000, "R6 set");
      for (int p = 0; p < 2; p++) begin
         for (int h = 1; h <= 12; h++) begin
            cur_hour = 6'(bcd(h)); cur_pm = p[0];
            step("R6 hour sweep");
         end
      end

      // R8: held match fires once, rearms after a miss
      cur_hour = 6'h11; cur_pm = 1'b1;
      step("R8 hold"); step("R8 hold"); step("R8 hold");
      cur_pm = 1'b0; step("R8 miss");
      cur_pm = 1'b1; step("R8 rematch");
      rd(4'd1, 32'h1, "R9 flag reads");

      // R3: lock blocks config write and flag clear
      wr_lock = 1'b1;
      wr(4'd0, 32'h0000_0080, "R3 locked write");
      rd(4'd0, 32'h00D1_0000, "R3 word kept");
      wr(4'd1, 32'h1, "R3 locked clear");
      rd(4'd1, 32'h1, "R3 flag kept");
      wr_lock = 1'b0;
      wr(4'd1, 32'h1, "R9 clear");

      // R9: event and clear in the same cycle -> event wins
      cur_pm = 1'b0; step("R9 miss");
      cur_pm = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h1; reg_wen = 1'b1;
      step("R9 set beats clear");

      // R10: three-step update of seconds
      wr(4'd0, 32'h0000_0010, "R10 disabled");
      cur_sec = 7'h20;
      wr(4'd0, 32'h0000_0020, "R10 new value");
      step("R10 still off"); step("R10 still off");
      wr(4'd0, 32'h0000_00A0, "R10 enable");
      step("R10 fires");
      rd(4'd0, 32'h0000_00A0, "R10 readback");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule